// File: doc/BRIEF.md
# Flash controller register sequencer

This block is the register front end of an embedded flash array. A host reaches it through a plain 32-bit register port (byte offset, write data, write strobe, combinational read data). It exposes three registers: a key register, a status register and a control register. The control register starts out locked. Only a fixed two-word unlock sequence opens it, and writing its lock bit closes it again. Once it is open, software sets up program, sector erase or mass erase and launches the operation through the start bit.

The flash array stands behind the block as a timed back end. A launched operation holds the busy flag for a parameterised number of cycles, a long count for erases and a short count for programs. When the operation ends, a one-cycle completion strobe reports the kind of operation and the byte range it covered. The array is split into sectors of different sizes, so an erase reports the base and length of the sector it selected.

Program operations start from a separate array write port that carries an address, an access width and data. Misuse of the block sets sticky error flags in the status register, and software clears them by writing ones. An error-injection input marks one sector as write protected.

Top module: `flash_ctl_seq`

## Requirements
- R1: After reset the control register (offset 0x10) reads 0x80000000 (bit 31 = locked) and the status register (offset 0x0C) reads 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x04) clears control bit 31.
- R3: A wrong key value, or any key write out of sequence, leaves the block locked until the next reset, even if the correct pair follows.
- R4: While locked, control writes change no control field, launch nothing and set no error flag.
- R5: A control write with bit 31 set relocks the block and loads the other fields from the same write. A fresh key pair then unlocks it again.
- R6: A control write with start (bit 16) and sector erase (bit 1) launches an erase of the sector given in bits 6:3. Busy (status bit 16) holds for ERASE_CYCLES cycles. In the next cycle done_vld pulses with done_op=2, done_addr set to the sector base and done_len set to the sector size. Sectors 0-3 are 16 KB, sector 4 is 64 KB and sectors 5-11 are 128 KB, laid out contiguously from offset 0.
- R7: Mass erase (bit 2) with start launches only if the stored mass-erase bit was already set by an earlier write. Otherwise the sequence-error flag (bit 7) is set. A launched mass erase completes with done_op=3, done_addr 0 and done_len equal to the array size.
- R8: With the block unlocked and the program bit (bit 0) set, an array write whose width code (0=8, 1=16, 2=32, 3=64 bits) equals control bits 9:8 and whose address is aligned to that width holds busy for PROG_CYCLES cycles. It then pulses done_vld with done_op=1, the write address, a length of 1<<width bytes, and the data masked to that width.
- R9: A faulty array write sets exactly one flag and launches nothing. The checks run in this priority order: locked or program bit clear gives sequence error (bit 7); width mismatch gives parallelism error (bit 6); misaligned address gives alignment error (bit 5).
- R10: A control or array write while busy is ignored and sets the operation-error flag (bit 1).
- R11: While wp_en is high, an erase of sector wp_sector, any mass erase, or a program into that sector sets the write-protect flag (bit 4) and launches nothing.
- R12: Writing the status register clears each error flag whose data bit is 1 and leaves flags whose data bit is 0.
- R13: A start with a sector number of 12 or above, or with neither erase bit set, sets the sequence-error flag and launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| arr_we | input | 1 | Array write strobe (program request) |
| arr_addr | input | ADDR_W | Array byte offset |
| arr_size | input | 2 | Access width code |
| arr_wdata | input | 64 | Array write data |
| wp_en | input | 1 | Error injection: one sector write protected |
| wp_sector | input | 4 | Protected sector number |
| busy | output | 1 | Operation in progress |
| done_vld | output | 1 | One-cycle completion strobe |
| done_op | output | 2 | Completed operation kind |
| done_addr | output | ADDR_W+1 | Start offset of the completed operation |
| done_len | output | ADDR_W+1 | Byte length of the completed operation |
| done_data | output | 64 | Programmed data, masked to the width |

## Verification
The assertions take for granted that the register port and the array port never strobe in the same cycle. Under that assumption, a status-clear write and a new sequence error cannot collide, and a busy-time control write is the only control write that cycle. Every strobe in the stimulus lasts exactly one cycle, and the two ports are driven strictly one after the other. The randomised program traffic picks widths, addresses and the protected sector independently, so mismatched, misaligned and protected cases all occur next to legal ones.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   // register byte offsets
   localparam logic [4:0] OFS_KEY  = 5'h04;
   localparam logic [4:0] OFS_STAT = 5'h0C;
   localparam logic [4:0] OFS_CTRL = 5'h10;

   // unlock words, accepted only in this order
   localparam logic [31:0] UNLOCK_W0 = 32'h4567_0123;
   localparam logic [31:0] UNLOCK_W1 = 32'hCDEF_89AB;

   // control bit positions
   localparam int C_PROG   = 0;
   localparam int C_SERASE = 1;
   localparam int C_MERASE = 2;
   localparam int C_SNB    = 3;
   localparam int C_SNB_W  = 4;
   localparam int C_PSZ    = 8;
   localparam int C_START  = 16;
   localparam int C_LOCK   = 31;

   // status bit positions
   localparam int S_BUSY = 16;
   localparam int S_SEQ  = 7;
   localparam int S_PAR  = 6;
   localparam int S_ALN  = 5;
   localparam int S_WP   = 4;
   localparam int S_OPE  = 1;
   localparam logic [7:0] ERR_MASK = 8'hF2;

   typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SERASE, OP_MERASE} op_e;
   typedef enum logic [1:0] {LK_WAIT0, LK_WAIT1, LK_OPEN, LK_JAM} lock_e;

   typedef struct packed {
      logic [1:0]         psz;
      logic [C_SNB_W-1:0] snb;
      logic               merase;
      logic               serase;
      logic               prog;
   } ctl_t;
endpackage

// File: rtl/flash_key_lock.sv
module flash_key_lock
   import flash_seq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_we,
   input  logic [31:0] key_data,
   input  logic        relock,
   output logic        unlocked,
   output logic        jammed
);
   lock_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         LK_WAIT0: if (key_we) st_d = (key_data == UNLOCK_W0) ? LK_WAIT1 : LK_JAM;
         LK_WAIT1: if (key_we) st_d = (key_data == UNLOCK_W1) ? LK_OPEN : LK_JAM;
         LK_OPEN: begin
            if (key_we)      st_d = LK_JAM;
            else if (relock) st_d = LK_WAIT0;
         end
         default: st_d = LK_JAM;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LK_WAIT0;
      else        st_q <= st_d;
   end

   assign unlocked = (st_q == LK_OPEN);
   assign jammed   = (st_q == LK_JAM);
endmodule

// File: rtl/flash_sector_map.sv
module flash_sector_map #(
   parameter int NUM_SECTORS = 12,
   parameter int SMALL_CNT   = 4,
   parameter int SMALL_KB    = 16,
   parameter int MID_KB      = 64,
   parameter int BIG_KB      = 128,
   parameter int ADDR_W      = 20,
   parameter int SNB_W       = 4
) (
   input  logic [SNB_W-1:0]  sel_idx,
   output logic [ADDR_W:0]   sel_base,
   output logic [ADDR_W:0]   sel_len,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic [SNB_W-1:0]  probe_idx
);
   localparam int LEN_W = ADDR_W + 1;

   function automatic int sec_len(input int i);
      if (i < SMALL_CNT)       return SMALL_KB * 1024;
      else if (i == SMALL_CNT) return MID_KB * 1024;
      else                     return BIG_KB * 1024;
   endfunction

   function automatic int sec_base(input int i);
      int acc = 0;
      for (int j = 0; j < i; j++) acc += sec_len(j);
      return acc;
   endfunction

   logic [LEN_W-1:0]       base_tab [NUM_SECTORS];
   logic [LEN_W-1:0]       len_tab  [NUM_SECTORS];
   logic [NUM_SECTORS-1:0] hit;

   for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sec
      assign base_tab[g] = LEN_W'(sec_base(g));
      assign len_tab[g]  = LEN_W'(sec_len(g));
      assign hit[g] = ({1'b0, probe_addr} >= base_tab[g]) &&
                      ({1'b0, probe_addr} <  (base_tab[g] + len_tab[g]));
   end

   always_comb begin
      sel_base  = '0;
      sel_len   = '0;
      probe_idx = '0;
      for (int i = 0; i < NUM_SECTORS; i++) begin
         if (sel_idx == SNB_W'(i)) begin
            sel_base = base_tab[i];
            sel_len  = len_tab[i];
         end
         if (hit[i]) probe_idx = SNB_W'(i);
      end
   end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
   parameter int ERASE_CYCLES = 24,
   parameter int PROG_CYCLES  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic long_op,
   output logic busy,
   output logic finish
);
   localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(ERASE_CYCLES);
   localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(PROG_CYCLES);

   if (ERASE_CYCLES < 1 || PROG_CYCLES < 1) begin : g_bad_cycles
      $error("flash_op_timer: cycle counts must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         finish <= 1'b0;
      end else begin
         finish <= (cnt_q == CNT_W'(1));
         if (launch)            cnt_q <= long_op ? LONG_LD : SHORT_LD;
         else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/flash_ctl_seq.sv
module flash_ctl_seq
   import flash_seq_pkg::*;
#(
   parameter int NUM_SECTORS  = 12,
   parameter int SMALL_CNT    = 4,
   parameter int SMALL_KB     = 16,
   parameter int MID_KB       = 64,
   parameter int BIG_KB       = 128,
   parameter int ADDR_W       = 20,
   parameter int ERASE_CYCLES = 24,
   parameter int PROG_CYCLES  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              arr_we,
   input  logic [ADDR_W-1:0] arr_addr,
   input  logic [1:0]        arr_size,
   input  logic [63:0]       arr_wdata,
   input  logic              wp_en,
   input  logic [3:0]        wp_sector,
   output logic              busy,
   output logic              done_vld,
   output logic [1:0]        done_op,
   output logic [ADDR_W:0]   done_addr,
   output logic [ADDR_W:0]   done_len,
   output logic [63:0]       done_data
);
   localparam int LEN_W       = ADDR_W + 1;
   localparam int ARRAY_BYTES = SMALL_CNT * SMALL_KB * 1024 + MID_KB * 1024 +
                                (NUM_SECTORS - SMALL_CNT - 1) * BIG_KB * 1024;

   if (NUM_SECTORS <= SMALL_CNT || NUM_SECTORS > (1 << C_SNB_W)) begin : g_bad_count
      $error("flash_ctl_seq: sector count out of range");
   end
   if (ADDR_W < 3 || ARRAY_BYTES > (1 << ADDR_W)) begin : g_bad_addr
      $error("flash_ctl_seq: ADDR_W cannot cover the array");
   end

   // register decode
   logic wr_key, wr_stat, wr_ctl;
   assign wr_key  = reg_we && (reg_addr == OFS_KEY);
   assign wr_stat = reg_we && (reg_addr == OFS_STAT);
   assign wr_ctl  = reg_we && (reg_addr == OFS_CTRL);

   logic unused_wbits;
   assign unused_wbits = ^{reg_wdata[30:17], reg_wdata[15:10]};

   ctl_t ctl_q, ctl_new;
   always_comb begin
      ctl_new.psz    = reg_wdata[C_PSZ +: 2];
      ctl_new.snb    = reg_wdata[C_SNB +: C_SNB_W];
      ctl_new.merase = reg_wdata[C_MERASE];
      ctl_new.serase = reg_wdata[C_SERASE];
      ctl_new.prog   = reg_wdata[C_PROG];
   end

   logic unlocked, jammed, relock;
   flash_key_lock u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_we   (wr_key),
      .key_data (reg_wdata),
      .relock   (relock),
      .unlocked (unlocked),
      .jammed   (jammed)
   );

   logic [LEN_W-1:0]   sec_base, sec_len;
   logic [C_SNB_W-1:0] probe_idx;
   flash_sector_map #(
      .NUM_SECTORS (NUM_SECTORS),
      .SMALL_CNT   (SMALL_CNT),
      .SMALL_KB    (SMALL_KB),
      .MID_KB      (MID_KB),
      .BIG_KB      (BIG_KB),
      .ADDR_W      (ADDR_W),
      .SNB_W       (C_SNB_W)
   ) u_map (
      .sel_idx    (ctl_new.snb),
      .sel_base   (sec_base),
      .sel_len    (sec_len),
      .probe_addr (arr_addr),
      .probe_idx  (probe_idx)
   );

   // operation decisions
   logic        launch, ctl_load;
   op_e         lop;
   logic [7:0]  err_set;
   logic [3:0]  size_mask;
   logic        misalign;
   logic [63:0] data_mask;

   assign size_mask = (4'd1 << arr_size) - 4'd1;
   assign misalign  = (arr_addr[2:0] & size_mask[2:0]) != 3'b000;

   always_comb begin
      unique case (arr_size)
         2'd0:    data_mask = 64'h0000_0000_0000_00FF;
         2'd1:    data_mask = 64'h0000_0000_0000_FFFF;
         2'd2:    data_mask = 64'h0000_0000_FFFF_FFFF;
         default: data_mask = '1;
      endcase
   end

   always_comb begin
      launch   = 1'b0;
      lop      = OP_NONE;
      relock   = 1'b0;
      ctl_load = 1'b0;
      err_set  = '0;
      if (wr_ctl) begin
         if (busy) begin
            err_set[S_OPE] = 1'b1;
         end else if (unlocked) begin
            ctl_load = 1'b1;
            if (reg_wdata[C_LOCK]) begin
               relock = 1'b1;
            end else if (reg_wdata[C_START]) begin
               if (ctl_new.merase && !ctl_new.serase) begin
                  if (!ctl_q.merase)  err_set[S_SEQ] = 1'b1;
                  else if (wp_en)     err_set[S_WP]  = 1'b1;
                  else begin
                     launch = 1'b1;
                     lop    = OP_MERASE;
                  end
               end else if (ctl_new.serase && !ctl_new.merase) begin
                  if (int'(ctl_new.snb) >= NUM_SECTORS)          err_set[S_SEQ] = 1'b1;
                  else if (wp_en && (wp_sector == ctl_new.snb))  err_set[S_WP]  = 1'b1;
                  else begin
                     launch = 1'b1;
                     lop    = OP_SERASE;
                  end
               end else begin
                  err_set[S_SEQ] = 1'b1;
               end
            end
         end
      end
      if (arr_we) begin
         if (busy || launch)                     err_set[S_OPE] = 1'b1;
         else if (!unlocked || !ctl_q.prog)      err_set[S_SEQ] = 1'b1;
         else if (arr_size != ctl_q.psz)         err_set[S_PAR] = 1'b1;
         else if (misalign)                      err_set[S_ALN] = 1'b1;
         else if (wp_en && probe_idx == wp_sector) err_set[S_WP] = 1'b1;
         else begin
            launch = 1'b1;
            lop    = OP_PROG;
         end
      end
   end

   // state
   logic [7:0]       err_q, err_clr;
   op_e              op_q;
   logic [LEN_W-1:0] op_addr_q, op_len_q;
   logic [63:0]      op_data_q;

   assign err_clr = wr_stat ? (reg_wdata[7:0] & ERR_MASK) : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= '0;
         err_q     <= '0;
         op_q      <= OP_NONE;
         op_addr_q <= '0;
         op_len_q  <= '0;
         op_data_q <= '0;
      end else begin
         if (ctl_load) ctl_q <= ctl_new;
         err_q <= (err_q & ~err_clr) | (err_set & ERR_MASK);
         if (launch) begin
            op_q <= lop;
            unique case (lop)
               OP_PROG: begin
                  op_addr_q <= {1'b0, arr_addr};
                  op_len_q  <= LEN_W'(1) << arr_size;
                  op_data_q <= arr_wdata & data_mask;
               end
               OP_SERASE: begin
                  op_addr_q <= sec_base;
                  op_len_q  <= sec_len;
                  op_data_q <= '0;
               end
               default: begin
                  op_addr_q <= '0;
                  op_len_q  <= LEN_W'(ARRAY_BYTES);
                  op_data_q <= '0;
               end
            endcase
         end
      end
   end

   flash_op_timer #(
      .ERASE_CYCLES (ERASE_CYCLES),
      .PROG_CYCLES  (PROG_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch),
      .long_op (lop != OP_PROG),
      .busy    (busy),
      .finish  (done_vld)
   );

   assign done_op   = op_q;
   assign done_addr = op_addr_q;
   assign done_len  = op_len_q;
   assign done_data = op_data_q;

   always_comb begin
      unique case (reg_addr)
         OFS_CTRL: reg_rdata = {!unlocked, 21'b0, ctl_q.psz, 1'b0, ctl_q.snb,
                                ctl_q.merase, ctl_q.serase, ctl_q.prog};
         OFS_STAT: reg_rdata = {15'b0, busy, 8'b0, err_q};
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/flash_ctl_seq_chk.sv
module flash_ctl_seq_chk
   import flash_seq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [4:0] reg_addr,
   input logic       reg_we,
   input logic       wdata_b7,
   input logic       arr_we,
   input logic       busy,
   input logic       done_vld,
   input logic [7:0] err_q,
   input logic [8:0] ctl_bits,
   input logic       unlocked,
   input logic       jammed
);
   // R6
   busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_vld);

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_vld |-> ($past(busy) && !busy));

   // R4
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFS_CTRL && !unlocked && !busy) |=> $stable(ctl_bits));

   // R10
   busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFS_CTRL && busy) |=> err_q[S_OPE]);

   // R12
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFS_STAT && wdata_b7 && !arr_we) |=> !err_q[S_SEQ]);

   // R3
   jam_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jammed |=> (jammed && !unlocked));

   // R2
   unlock_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(reg_we && reg_addr == OFS_KEY));
endmodule

bind flash_ctl_seq flash_ctl_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_we   (reg_we),
   .wdata_b7 (reg_wdata[7]),
   .arr_we   (arr_we),
   .busy     (busy),
   .done_vld (done_vld),
   .err_q    (err_q),
   .ctl_bits (ctl_q),
   .unlocked (unlocked),
   .jammed   (jammed)
);

// File: tb/flash_ctl_seq_tb.sv
module flash_ctl_seq_tb;
   localparam int AW = 20;
   localparam int EC = 24;
   localparam int PC = 3;
   localparam logic [4:0] A_KEY = 5'h04, A_STAT = 5'h0C, A_CTRL = 5'h10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] reg_addr = '0;
   logic reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic arr_we = 1'b0;
   logic [AW-1:0] arr_addr = '0;
   logic [1:0] arr_size = '0;
   logic [63:0] arr_wdata = '0;
   logic wp_en = 1'b0;
   logic [3:0] wp_sector = '0;
   logic busy, done_vld;
   logic [1:0] done_op;
   logic [AW:0] done_addr, done_len;
   logic [63:0] done_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   flash_ctl_seq #(.ADDR_W(AW), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_we(arr_we),
      .arr_addr(arr_addr), .arr_size(arr_size), .arr_wdata(arr_wdata),
      .wp_en(wp_en), .wp_sector(wp_sector), .busy(busy), .done_vld(done_vld),
      .done_op(done_op), .done_addr(done_addr), .done_len(done_len),
      .done_data(done_data));

   function automatic logic [AW:0] exp_base(input int s);
      if (s < 4)       return (AW+1)'(s * 16384);
      else if (s == 4) return (AW+1)'(65536);
      else             return (AW+1)'((s - 4) * 131072);
   endfunction

   function automatic logic [AW:0] exp_len(input int s);
      if (s < 4)       return (AW+1)'(16384);
      else if (s == 4) return (AW+1)'(65536);
      else             return (AW+1)'(131072);
   endfunction

   function automatic int sector_of(input logic [AW-1:0] a);
      if (a < 65536)       return int'(a) / 16384;
      else if (a < 131072) return 4;
      else                 return 4 + int'(a) / 131072;
   endfunction

   function automatic logic [63:0] wmask(input logic [1:0] s);
      return (s == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << s)) - 64'd1);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic arr_wr(input logic [AW-1:0] a, input logic [1:0] s, input logic [63:0] d);
      @(negedge clk);
      arr_addr = a; arr_size = s; arr_wdata = d; arr_we = 1'b1;
      @(negedge clk);
      arr_we = 1'b0;
   endtask

   task automatic wait_op(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic unlock();
      reg_wr(A_KEY, 32'h4567_0123);
      reg_wr(A_KEY, 32'hCDEF_89AB);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int n, seed;
      seed = $urandom(32'h1F2E3D);
      do_reset();

      reg_rd(A_CTRL, rd); chk("R1 ctrl after reset", rd, 32'h8000_0000);
      reg_rd(A_STAT, rd); chk("R1 stat after reset", rd, 0);

      // locked control write
      reg_wr(A_CTRL, 32'h0001_0002);
      reg_rd(A_CTRL, rd); chk("R4 locked ctrl unchanged", rd, 32'h8000_0000);
      chk("R4 locked no busy", busy, 0);
      reg_rd(A_STAT, rd); chk("R4 locked no error", rd, 0);

      // out of order keys
      reg_wr(A_KEY, 32'hCDEF_89AB);
      unlock();
      reg_rd(A_CTRL, rd); chk("R3 jammed after bad order", rd[31], 1);
      do_reset();
      reg_wr(A_KEY, 32'h4567_0123);
      reg_wr(A_KEY, 32'h1234_5678);
      unlock();
      reg_rd(A_CTRL, rd); chk("R3 jammed after bad value", rd[31], 1);
      do_reset();

      unlock();
      reg_rd(A_CTRL, rd); chk("R2 unlocked", rd, 0);

      // sector erase of every sector
      for (int s = 0; s < 12; s++) begin
         reg_wr(A_CTRL, 32'h0001_0002 | (s << 3));
         wait_op(n);
         chk($sformatf("R6 erase cycles s%0d", s), n, EC);
         chk($sformatf("R6 done s%0d", s), done_vld, 1);
         chk($sformatf("R6 op s%0d", s), done_op, 2);
         chk($sformatf("R6 base s%0d", s), done_addr, exp_base(s));
         chk($sformatf("R6 len s%0d", s), done_len, exp_len(s));
      end
      reg_rd(A_STAT, rd); chk("R6 no error", rd, 0);

      // invalid starts
      reg_wr(A_CTRL, 32'h0001_0062);
      reg_rd(A_STAT, rd); chk("R13 sector 12", rd, 32'h80);
      chk("R13 no busy", busy, 0);
      reg_wr(A_CTRL, 32'h0000_0201);
      arr_wr(20'h00100, 2'd1, 64'h1234);
      reg_rd(A_STAT, rd); chk("R9 parallelism", rd, 32'hC0);
      reg_wr(A_STAT, 32'h80);
      reg_rd(A_STAT, rd); chk("R12 partial clear", rd, 32'h40);
      reg_wr(A_STAT, 32'h00);
      reg_rd(A_STAT, rd); chk("R12 zero write keeps", rd, 32'h40);
      reg_wr(A_STAT, 32'h40);
      reg_rd(A_STAT, rd); chk("R12 full clear", rd, 0);
      reg_wr(A_CTRL, 32'h0001_0000);
      reg_rd(A_STAT, rd); chk("R13 no op bit", rd, 32'h80);
      reg_wr(A_STAT, 32'hFF);
      reg_wr(A_CTRL, 32'h0000_0000);
      arr_wr(20'h00200, 2'd0, 64'h55);
      reg_rd(A_STAT, rd); chk("R9 program bit clear", rd, 32'h80);
      chk("R9 no busy", busy, 0);
      reg_wr(A_STAT, 32'hFF);
      reg_wr(A_CTRL, 32'h0000_0201);
      arr_wr(20'h00102, 2'd2, 64'h1);
      reg_rd(A_STAT, rd); chk("R9 alignment", rd, 32'h20);
      reg_wr(A_STAT, 32'hFF);

      // mass erase
      reg_wr(A_CTRL, 32'h0001_0004);
      reg_rd(A_STAT, rd); chk("R7 single step rejected", rd, 32'h80);
      reg_wr(A_STAT, 32'hFF);
      reg_wr(A_CTRL, 32'h0001_0004);
      chk("R7 busy", busy, 1);
      reg_wr(A_CTRL, 32'h0000_0001);
      arr_wr(20'h0, 2'd0, 64'h0);
      reg_rd(A_STAT, rd); chk("R10 op error", rd, 32'h1_0002);
      wait_op(n);
      chk("R7 done", done_vld, 1);
      chk("R7 op", done_op, 3);
      chk("R7 addr", done_addr, 0);
      chk("R7 len", done_len, 21'h10_0000);
      reg_rd(A_CTRL, rd); chk("R10 ctrl untouched", rd, 32'h4);
      reg_wr(A_STAT, 32'hFF);

      // relock
      reg_wr(A_CTRL, 32'h8000_0000);
      reg_rd(A_CTRL, rd); chk("R5 relocked", rd, 32'h8000_0000);
      unlock();
      reg_rd(A_CTRL, rd); chk("R5 unlocked again", rd, 0);

      // write protection
      wp_en = 1'b1; wp_sector = 4'd5;
      reg_wr(A_CTRL, 32'h0001_002A);
      reg_rd(A_STAT, rd); chk("R11 protected erase", rd, 32'h10);
      reg_wr(A_STAT, 32'hFF);
      reg_wr(A_CTRL, 32'h0000_0004);
      reg_wr(A_CTRL, 32'h0001_0004);
      reg_rd(A_STAT, rd); chk("R11 protected mass", rd, 32'h10);
      reg_wr(A_STAT, 32'hFF);
      reg_wr(A_CTRL, 32'h0001_0032);
      wait_op(n);
      chk("R11 neighbour erased", done_addr, exp_base(6));
      wp_en = 1'b0;

      // random programs
      for (int i = 0; i < 60; i++) begin
         logic [1:0] psz, sz;
         logic [AW-1:0] a;
         logic [63:0] d;
         logic [31:0] ee;
         psz = 2'($urandom % 4);
         sz  = ($urandom % 4 == 0) ? 2'($urandom % 4) : psz;
         a   = AW'($urandom);
         if ($urandom % 3 != 0) a = a & ~AW'((1 << sz) - 1);
         d   = {$urandom, $urandom};
         wp_en = ($urandom % 3 == 0);
         wp_sector = 4'($urandom % 12);
         reg_wr(A_CTRL, 32'h1 | (32'(psz) << 8));
         arr_wr(a, sz, d);
         if (sz != psz)                                      ee = 32'h40;
         else if ((int'(a) % (1 << sz)) != 0)                ee = 32'h20;
         else if (wp_en && sector_of(a) == int'(wp_sector))  ee = 32'h10;
         else                                                ee = 0;
         if (ee == 0) begin
            wait_op(n);
            chk("R8 program cycles", n, PC);
            chk("R8 done", done_vld, 1);
            chk("R8 op", done_op, 1);
            chk("R8 addr", done_addr, {1'b0, a});
            chk("R8 len", done_len, (AW+1)'(1) << sz);
            chk("R8 data", done_data, d & wmask(sz));
         end else begin
            reg_rd(A_STAT, rd);
            chk("R9 R11 random error", rd, ee);
            reg_wr(A_STAT, 32'hFF);
         end
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule